// File: doc/BRIEF.md
# DMA Channel Start, Chain and Abort Controller

This block is the control core for a small, parameterised group of DMA channels. It moves no data of its own. Each channel holds a control word, a source address, a destination address and a remaining-beat count. The block decides when a channel starts and when it may issue its next beat to a separate data mover. It also handles channel-to-channel chaining on completion, abort with drain of outstanding beats, and two interrupt outputs built from sticky per-channel flags.

Software reaches the block through a simple write port. Each channel register has two addresses. The plain address only loads the register. The trigger address loads it and then starts the channel. A global area provides a multi-channel start, an abort mask, two interrupt masks and a write-one-to-clear status register.

The data mover sees a per-channel `issue_en` grant. It reports each beat it accepts on `beat_take` and each beat it retires on `beat_done`. Beats can be paced by request lines or timer ticks, which feed a per-channel credit counter. A channel can also run unpaced.

Top module: `dmatc_top`

## Requirements
- R1: Channel write addresses are {0, channel, go, reg}, with reg 0 = control, 1 = source, 2 = destination and 3 = count. With go = 0 the write only loads the register. With go = 1 and nonzero data the write loads the register and then starts the channel if its enable bit is set. `busy` rises in the cycle after the write, and a start on an already busy channel has no effect.
- R2: Writing global offset 0 starts, in the same cycle, every channel whose data bit n is set (bit n maps to channel n).
- R3: Control bits [7:2] select the pacing source:
  - a value below NDREQ selects `dreq[n]`;
  - 0x3b to 0x3e select `tmr[0]` to `tmr[3]`;
  - 0x3f means always ready.
  A paced busy channel gains one credit per cycle in which its selected line is high, loses one per accepted beat, and may issue only while it holds credit. A pulse on any unselected line has no effect.
- R4: Control bits [11:8] name a chain target. When a channel completes, the target starts in the same cycle that the completing channel drops `busy`. A target equal to the channel's own index means no chaining.
- R5: Control bit 0 is enable. While it is 0, the channel issues nothing and ignores starts, and `busy` stays as it was. Setting it again resumes issue with the remaining count.
- R6: Control bit 1 is quiet. A quiet channel sets no status bit on completion. A zero written through the source, destination or count trigger address never starts a channel, and it sets the status bit of a quiet channel.
- R7: Writing bit n to global offset 1 aborts busy channel n. `issue_en` drops at once and `abort_busy[n]` reads 1 until every accepted beat has retired. In the next cycle `busy` and `abort_busy` fall together, with no status bit set and no chain start.
- R8: Global offsets 2 and 3 hold two interrupt masks. `irq_a` is the OR of status AND the first mask, and `irq_b` is the OR of status AND the second mask.
- R9: Status bits are sticky. Writing 1s to global offset 4 clears those bits. A new event in the same cycle wins over the clear.
- R10: After reset, every control word has enable 1, quiet 0, select 0x3f, chain-to = own index, bit 12 = 1, bit 13 = 0 and bits [15:14] = 2, with all other bits 0 (0x90FD plus index<<8). Busy, status and `issue_en` are 0.
- R11: Each accepted beat (`beat_take` while `issue_en`) lowers the count by one. A busy channel completes when its count is zero and it has no beats in flight. It then drops `busy` and sets its status bit unless it is quiet.
- R12: `issue_en` is high only when the channel is busy, enabled, not aborting, has a nonzero count, has credit or is unpaced, and has fewer than 2^INFL_W−1 beats in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | CH_W+4 | Write address: MSB selects the global area |
| wr_data | input | 32 | Write data |
| dreq | input | NDREQ | Peripheral request lines, one credit per high cycle |
| tmr | input | NTIMER | Timer tick lines |
| beat_take | input | NCH | Data mover accepted a beat (valid only with issue_en) |
| beat_done | input | NCH | Data mover retired a beat |
| issue_en | output | NCH | Channel may issue a beat |
| busy | output | NCH | Channel sequence in progress |
| abort_busy | output | NCH | Abort still draining in-flight beats |
| cnt_flat | output | NCH*CNT_W | Remaining beat count per channel |
| ctrl_flat | output | NCH*32 | Control word per channel |
| rda_flat | output | NCH*ADDR_W | Source address per channel |
| wra_flat | output | NCH*ADDR_W | Destination address per channel |
| irq_status | output | NCH | Sticky interrupt status |
| irq_a | output | 1 | First interrupt output |
| irq_b | output | 1 | Second interrupt output |

## Verification
The bench builds the block with four channels, sixteen request lines, four timers, a 16-bit count and a two-bit in-flight counter. Four channels are enough to run three at once, to chain one into another and to hold a quiet channel beside loud ones. The two-bit counter lets the in-flight cap of three beats be reached in three cycles. With sixteen request lines, the bench can pulse a neighbouring line and a timer to show that unselected sources give no credit.

// File: rtl/dmatc_pkg.sv
package dmatc_pkg;

    // control word field positions (decoded by the channel and the chain router)
    localparam int F_EN     = 0;
    localparam int F_QUIET  = 1;
    localparam int F_SEL    = 2;
    localparam int SEL_W    = 6;
    localparam int F_CHAIN  = 8;
    localparam int CHAIN_W  = 4;
    localparam int F_RDINC  = 12;
    localparam int F_SIZE   = 14;

    localparam logic [SEL_W-1:0] SEL_TMR0  = 6'h3b;
    localparam logic [SEL_W-1:0] SEL_FORCE = 6'h3f;
    localparam int               N_TMR_SEL = 4;

    // global register offsets
    localparam logic [2:0] GR_MULTI = 3'd0;
    localparam logic [2:0] GR_ABORT = 3'd1;
    localparam logic [2:0] GR_IEA   = 3'd2;
    localparam logic [2:0] GR_IEB   = 3'd3;
    localparam logic [2:0] GR_STAT  = 3'd4;

    // channel register selector (low two offset bits)
    typedef enum logic [1:0] {
        RG_CTRL = 2'd0,
        RG_RDA  = 2'd1,
        RG_WRA  = 2'd2,
        RG_CNT  = 2'd3
    } chreg_e;

    function automatic logic [31:0] ctrl_reset(input int unsigned ch);
        logic [31:0] v;
        v                     = '0;
        v[F_EN]               = 1'b1;
        v[F_SEL +: SEL_W]     = SEL_FORCE;
        v[F_CHAIN +: CHAIN_W] = ch[CHAIN_W-1:0];
        v[F_RDINC]            = 1'b1;
        v[F_SIZE +: 2]        = 2'd2;
        return v;
    endfunction

endpackage

// File: rtl/dmatc_req_mux.sv
module dmatc_req_mux
    import dmatc_pkg::*;
#(
    parameter int NDREQ  = 16,
    parameter int NTIMER = 4
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [NDREQ-1:0]  dreq,
    input  logic [NTIMER-1:0] tmr,
    output logic              hit,
    output logic              always_on
);
    localparam int NT = (NTIMER < N_TMR_SEL) ? NTIMER : N_TMR_SEL;

    always_comb begin
        hit       = 1'b0;
        always_on = (sel == SEL_FORCE);
        for (int i = 0; i < NDREQ; i++) begin
            if (i < int'(SEL_TMR0) && sel == SEL_W'(i)) hit = dreq[i];
        end
        for (int j = 0; j < NT; j++) begin
            if (sel == SEL_TMR0 + SEL_W'(j)) hit = tmr[j];
        end
    end
endmodule

// File: rtl/dmatc_chan.sv
module dmatc_chan
    import dmatc_pkg::*;
#(
    parameter int IDX      = 0,
    parameter int NDREQ    = 16,
    parameter int NTIMER   = 4,
    parameter int CNT_W    = 16,
    parameter int ADDR_W   = 32,
    parameter int CREDIT_W = 3,
    parameter int INFL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_ctrl,
    input  logic              ld_rda,
    input  logic              ld_wra,
    input  logic              ld_cnt,
    input  logic [31:0]       wdata,
    input  logic              trig,
    input  logic              abort_req,
    input  logic [NDREQ-1:0]  dreq,
    input  logic [NTIMER-1:0] tmr,
    input  logic              beat_take,
    input  logic              beat_done,
    output logic [31:0]       ctrl_o,
    output logic [ADDR_W-1:0] rda_o,
    output logic [ADDR_W-1:0] wra_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              busy_o,
    output logic              issue_o,
    output logic              abort_o,
    output logic              done_o
);
    localparam logic [CREDIT_W-1:0] CREDIT_MAX = {CREDIT_W{1'b1}};
    localparam logic [INFL_W-1:0]   INFL_MAX   = {INFL_W{1'b1}};

    typedef struct packed {
        logic [31:0]         ctrl;
        logic [ADDR_W-1:0]   rda;
        logic [ADDR_W-1:0]   wra;
        logic [CNT_W-1:0]    cnt;
        logic                busy;
        logic                aborting;
        logic [CREDIT_W-1:0] credit;
        logic [INFL_W-1:0]   infl;
    } st_t;

    st_t st_d, st_q;
    logic req_hit, req_free, issue, take, done;

    dmatc_req_mux #(.NDREQ(NDREQ), .NTIMER(NTIMER)) u_mux (
        .sel       (st_q.ctrl[F_SEL +: SEL_W]),
        .dreq      (dreq),
        .tmr       (tmr),
        .hit       (req_hit),
        .always_on (req_free)
    );

    always_comb begin
        issue = st_q.busy && !st_q.aborting && st_q.ctrl[F_EN]
              && (st_q.cnt != '0)
              && (req_free || st_q.credit != '0)
              && (st_q.infl != INFL_MAX);
        take  = beat_take && issue;
        done  = st_q.busy && !st_q.aborting && (st_q.cnt == '0) && (st_q.infl == '0);

        st_d = st_q;

        // register loads
        if (ld_ctrl) st_d.ctrl = wdata;
        if (ld_rda)  st_d.rda  = ADDR_W'(wdata);
        if (ld_wra)  st_d.wra  = ADDR_W'(wdata);
        if (take)    st_d.cnt  = st_q.cnt - 1'b1;
        if (ld_cnt)  st_d.cnt  = CNT_W'(wdata);

        // in-flight beats
        if (take && !beat_done) begin
            st_d.infl = st_q.infl + 1'b1;
        end else if (!take && beat_done && st_q.infl != '0) begin
            st_d.infl = st_q.infl - 1'b1;
        end

        // pacing credit
        if (!st_q.busy) begin
            st_d.credit = '0;
        end else if (req_hit && !take && !req_free) begin
            if (st_q.credit != CREDIT_MAX) st_d.credit = st_q.credit + 1'b1;
        end else if (!req_hit && take && st_q.credit != '0) begin
            st_d.credit = st_q.credit - 1'b1;
        end

        // completion
        if (done) st_d.busy = 1'b0;

        // abort drain
        if (st_q.aborting && st_q.infl == '0) begin
            st_d.aborting = 1'b0;
            st_d.busy     = 1'b0;
        end
        if (abort_req && st_q.busy && !st_q.aborting) begin
            st_d.aborting = 1'b1;
            st_d.cnt      = '0;
        end

        // start
        if (trig && st_d.ctrl[F_EN] && (!st_q.busy || done) && !abort_req) begin
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.ctrl     <= ctrl_reset(IDX);
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o  = st_q.ctrl;
    assign rda_o   = st_q.rda;
    assign wra_o   = st_q.wra;
    assign cnt_o   = st_q.cnt;
    assign busy_o  = st_q.busy;
    assign issue_o = issue;
    assign abort_o = st_q.aborting;
    assign done_o  = done;
endmodule

// File: rtl/dmatc_irq.sv
module dmatc_irq #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_ev,
    input  logic           clr_we,
    input  logic           iea_we,
    input  logic           ieb_we,
    input  logic [NCH-1:0] wdata,
    output logic [NCH-1:0] status_o,
    output logic           irq_a,
    output logic           irq_b
);
    typedef struct packed {
        logic [NCH-1:0] stat;
        logic [NCH-1:0] iea;
        logic [NCH-1:0] ieb;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we) st_d.stat = st_q.stat & ~wdata;
        st_d.stat = st_d.stat | set_ev;
        if (iea_we) st_d.iea = wdata;
        if (ieb_we) st_d.ieb = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.stat;
    assign irq_a    = |(st_q.stat & st_q.iea);
    assign irq_b    = |(st_q.stat & st_q.ieb);
endmodule

// File: rtl/dmatc_top.sv
module dmatc_top
    import dmatc_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int NDREQ    = 16,
    parameter int NTIMER   = 4,
    parameter int CNT_W    = 16,
    parameter int ADDR_W   = 32,
    parameter int CREDIT_W = 3,
    parameter int INFL_W   = 2,
    localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int RA_W    = CH_W + 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [RA_W-1:0]       wr_addr,
    input  logic [31:0]           wr_data,
    input  logic [NDREQ-1:0]      dreq,
    input  logic [NTIMER-1:0]     tmr,
    input  logic [NCH-1:0]        beat_take,
    input  logic [NCH-1:0]        beat_done,
    output logic [NCH-1:0]        issue_en,
    output logic [NCH-1:0]        busy,
    output logic [NCH-1:0]        abort_busy,
    output logic [NCH*CNT_W-1:0]  cnt_flat,
    output logic [NCH*32-1:0]     ctrl_flat,
    output logic [NCH*ADDR_W-1:0] rda_flat,
    output logic [NCH*ADDR_W-1:0] wra_flat,
    output logic [NCH-1:0]        irq_status,
    output logic                  irq_a,
    output logic                  irq_b
);
    logic           glob_we, chan_we, go_bit, data_zero;
    logic [2:0]     offs;
    chreg_e         rsel;
    logic [CH_W-1:0] chsel;

    logic [NCH-1:0] ld_ctrl, ld_rda, ld_wra, ld_cnt;
    logic [NCH-1:0] trig, abort_req, done, chain_trig, null_ev, set_ev;
    logic [31:0]    ctrl_a [NCH];

    // address decode
    always_comb begin
        glob_we   = wr_en && wr_addr[RA_W-1];
        chan_we   = wr_en && !wr_addr[RA_W-1];
        offs      = wr_addr[2:0];
        go_bit    = wr_addr[2];
        rsel      = chreg_e'(wr_addr[1:0]);
        chsel     = wr_addr[CH_W+2:3];
        data_zero = (wr_data == '0);
    end

    // chain routing: a finishing channel starts its named target
    always_comb begin
        chain_trig = '0;
        for (int s = 0; s < NCH; s++) begin
            for (int t = 0; t < NCH; t++) begin
                if (done[s] && t != s && ctrl_a[s][F_CHAIN +: CHAIN_W] == CHAIN_W'(t)) begin
                    chain_trig[t] = 1'b1;
                end
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;

        always_comb begin
            hit          = chan_we && (chsel == CH_W'(c));
            ld_ctrl[c]   = hit && (rsel == RG_CTRL);
            ld_rda[c]    = hit && (rsel == RG_RDA);
            ld_wra[c]    = hit && (rsel == RG_WRA);
            ld_cnt[c]    = hit && (rsel == RG_CNT);
            null_ev[c]   = hit && go_bit && data_zero && (rsel != RG_CTRL)
                           && ctrl_a[c][F_QUIET];
            abort_req[c] = glob_we && (offs == GR_ABORT) && wr_data[c];
            trig[c]      = (hit && go_bit && !data_zero)
                         || (glob_we && (offs == GR_MULTI) && wr_data[c])
                         || chain_trig[c];
            set_ev[c]    = (done[c] && !ctrl_a[c][F_QUIET]) || null_ev[c];
        end

        dmatc_chan #(
            .IDX(c), .NDREQ(NDREQ), .NTIMER(NTIMER), .CNT_W(CNT_W),
            .ADDR_W(ADDR_W), .CREDIT_W(CREDIT_W), .INFL_W(INFL_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .ld_ctrl   (ld_ctrl[c]),
            .ld_rda    (ld_rda[c]),
            .ld_wra    (ld_wra[c]),
            .ld_cnt    (ld_cnt[c]),
            .wdata     (wr_data),
            .trig      (trig[c]),
            .abort_req (abort_req[c]),
            .dreq      (dreq),
            .tmr       (tmr),
            .beat_take (beat_take[c]),
            .beat_done (beat_done[c]),
            .ctrl_o    (ctrl_a[c]),
            .rda_o     (rda_flat[c*ADDR_W +: ADDR_W]),
            .wra_o     (wra_flat[c*ADDR_W +: ADDR_W]),
            .cnt_o     (cnt_flat[c*CNT_W +: CNT_W]),
            .busy_o    (busy[c]),
            .issue_o   (issue_en[c]),
            .abort_o   (abort_busy[c]),
            .done_o    (done[c])
        );

        assign ctrl_flat[c*32 +: 32] = ctrl_a[c];
    end

    dmatc_irq #(.NCH(NCH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ev   (set_ev),
        .clr_we   (glob_we && offs == GR_STAT),
        .iea_we   (glob_we && offs == GR_IEA),
        .ieb_we   (glob_we && offs == GR_IEB),
        .wdata    (wr_data[NCH-1:0]),
        .status_o (irq_status),
        .irq_a    (irq_a),
        .irq_b    (irq_b)
    );
endmodule

// File: rtl/dmatc_chk.sv
module dmatc_chk
    import dmatc_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int NDREQ    = 16,
    parameter int NTIMER   = 4,
    parameter int CNT_W    = 16,
    parameter int ADDR_W   = 32,
    localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int RA_W    = CH_W + 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [RA_W-1:0]       wr_addr,
    input logic [31:0]           wr_data,
    input logic [NDREQ-1:0]      dreq,
    input logic [NTIMER-1:0]     tmr,
    input logic [NCH-1:0]        beat_take,
    input logic [NCH-1:0]        beat_done,
    input logic [NCH-1:0]        issue_en,
    input logic [NCH-1:0]        busy,
    input logic [NCH-1:0]        abort_busy,
    input logic [NCH*CNT_W-1:0]  cnt_flat,
    input logic [NCH*32-1:0]     ctrl_flat,
    input logic [NCH*ADDR_W-1:0] rda_flat,
    input logic [NCH*ADDR_W-1:0] wra_flat,
    input logic [NCH-1:0]        irq_status,
    input logic                  irq_a,
    input logic                  irq_b
);
    logic stat_clr_we;
    assign stat_clr_we = wr_en && wr_addr[RA_W-1] && (wr_addr[2:0] == GR_STAT);

    for (genvar c = 0; c < NCH; c++) begin : g_a
        AST_ISSUE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            issue_en[c] |-> busy[c]); // R12
        AST_ISSUE_NONZERO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
            issue_en[c] |-> (cnt_flat[c*CNT_W +: CNT_W] != '0)); // R12
        AST_DISABLED_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_flat[c*32 + F_EN] |-> !issue_en[c]); // R5
        AST_ABORT_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
            abort_busy[c] |-> (!issue_en[c] && busy[c])); // R7
        AST_ABORT_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(abort_busy[c]) |-> !busy[c]); // R7
        AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_status[c] && !(stat_clr_we && wr_data[c])) |=> irq_status[c]); // R9
        AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (busy[c] && !wr_en && !beat_take[c] && !abort_busy[c])
            |=> $stable(cnt_flat[c*CNT_W +: CNT_W])); // R11
    end

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_a || irq_b) |-> (irq_status != '0)); // R8
endmodule

bind dmatc_top dmatc_chk #(
    .NCH(NCH), .NDREQ(NDREQ), .NTIMER(NTIMER), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/sim_dmatc_top.sv
module sim_dmatc_top;
    localparam int NCH = 4, NDREQ = 16, NTIMER = 4, CNT_W = 16, ADDR_W = 32;
    localparam int RA_W = 6;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  wr_en = 1'b0;
    logic [RA_W-1:0]       wr_addr = '0;
    logic [31:0]           wr_data = '0;
    logic [NDREQ-1:0]      dreq = '0;
    logic [NTIMER-1:0]     tmr = '0;
    logic [NCH-1:0]        beat_take = '0;
    logic [NCH-1:0]        beat_done = '0;
    logic [NCH-1:0]        issue_en, busy, abort_busy, irq_status;
    logic [NCH*CNT_W-1:0]  cnt_flat;
    logic [NCH*32-1:0]     ctrl_flat;
    logic [NCH*ADDR_W-1:0] rda_flat, wra_flat;
    logic                  irq_a, irq_b;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk; // 125 MHz

    dmatc_top #(.NCH(NCH), .NDREQ(NDREQ), .NTIMER(NTIMER), .CNT_W(CNT_W),
                .ADDR_W(ADDR_W)) u0 (.*);

    typedef struct packed {
        logic [5:0]  a;
        logic [31:0] d;
        logic [3:0]  busy;
        logic [3:0]  st;
    } vec_t;

    // channel c reg r at c*8+r (r+4 = trigger alias); global area at 32+offset
    localparam vec_t TBL [11] = '{
        '{6'd3,  32'd5,      4'b0000, 4'b0000},
        '{6'd7,  32'd5,      4'b0001, 4'b0000},
        '{6'd15, 32'd0,      4'b0001, 4'b0000},
        '{6'd8,  32'h91FF,   4'b0001, 4'b0000},
        '{6'd13, 32'd0,      4'b0001, 4'b0010},
        '{6'd36, 32'd2,      4'b0001, 4'b0000},
        '{6'd19, 32'd3,      4'b0001, 4'b0000},
        '{6'd27, 32'd2,      4'b0001, 4'b0000},
        '{6'd32, 32'hC,      4'b1101, 4'b0000},
        '{6'd14, 32'h100,    4'b1111, 4'b0000},
        '{6'd34, 32'hF,      4'b1101, 4'b0000}
    };

    function automatic logic [31:0] mk(input bit en, input bit q, input int sel, input int ch);
        return 32'(en) | (32'(q) << 1) | (32'(sel) << 2) | (32'(ch) << 8) | 32'h9000;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic beat(input int c);
        @(negedge clk); beat_take[c] = 1'b1;
        @(negedge clk); beat_take[c] = 1'b0; beat_done[c] = 1'b1;
        @(negedge clk); beat_done[c] = 1'b0;
    endtask

    function automatic logic [15:0] cnt_of(input int c);
        return cnt_flat[c*CNT_W +: CNT_W];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R10 reset state
        chk("R10 busy", 64'(busy), 0);
        chk("R10 status", 64'(irq_status), 0);
        chk("R10 issue", 64'(issue_en), 0);
        chk("R10 irq", 64'({irq_a, irq_b}), 0);
        for (int c = 0; c < NCH; c++)
            chk("R10 ctrl", 64'(ctrl_flat[c*32 +: 32]), 64'(32'h90FD + (c << 8)));

        // table: loads, triggers, null triggers, multi start, W1C (R1 R2 R6 R9)
        for (int i = 0; i < 11; i++) begin
            wr(TBL[i].a, TBL[i].d);
            chk($sformatf("R1 R2 R6 R9 busy vector %0d", i), 64'(busy), 64'(TBL[i].busy));
            chk($sformatf("R1 R2 R6 R9 status vector %0d", i), 64'(irq_status), 64'(TBL[i].st));
        end
        chk("R4 self chain off, ch1 quiet done", 64'(busy), 64'b1101);
        chk("R1 count loaded", 64'(cnt_of(0)), 5);
        chk("R12 issue set", 64'(issue_en), 64'b1101);

        // R11 five beats on channel 0
        beat(0);
        chk("R11 count step", 64'(cnt_of(0)), 4);
        for (int k = 0; k < 4; k++) beat(0);
        cyc(1);
        chk("R11 done busy", 64'(busy[0]), 0);
        chk("R11 done status", 64'(irq_status), 64'b0001);
        chk("R8 irq_a", 64'(irq_a), 1);
        chk("R8 irq_b", 64'(irq_b), 0);

        // R12 in-flight cap on channel 2
        wr(6'd19, 32'd10);
        @(negedge clk); beat_take[2] = 1'b1;
        cyc(3);
        beat_take[2] = 1'b0;
        chk("R12 cap reached", 64'(issue_en[2]), 0);
        chk("R11 count after three", 64'(cnt_of(2)), 7);
        beat_done[2] = 1'b1;
        cyc(3);
        beat_done[2] = 1'b0;
        chk("R12 cap released", 64'(issue_en[2]), 1);

        // R4 chain channel 2 -> channel 0
        wr(6'd16, mk(1, 0, 63, 0));
        wr(6'd3, 32'd1);
        for (int k = 0; k < 7; k++) beat(2);
        cyc(1);
        chk("R4 source idle", 64'(busy[2]), 0);
        chk("R4 target started", 64'(busy[0]), 1);
        chk("R4 status", 64'(irq_status), 64'b0101);
        wr(6'd35, 32'h4);
        chk("R8 irq_b", 64'(irq_b), 1);
        wr(6'd36, 32'h5);
        chk("R9 cleared", 64'(irq_status), 0);
        chk("R9 irq off", 64'({irq_a, irq_b}), 0);

        // R5 pause and resume channel 3, ignored start on disabled channel 1
        wr(6'd24, mk(0, 0, 63, 3));
        chk("R5 paused busy", 64'(busy[3]), 1);
        chk("R5 paused issue", 64'(issue_en[3]), 0);
        wr(6'd8, mk(0, 0, 63, 1));
        wr(6'd15, 32'd4);
        chk("R5 start ignored", 64'(busy[1]), 0);
        wr(6'd24, mk(1, 0, 63, 3));
        chk("R5 resume issue", 64'(issue_en[3]), 1);
        chk("R5 resume count", 64'(cnt_of(3)), 2);

        // R7 abort channel 0 with one beat in flight
        @(negedge clk); beat_take[0] = 1'b1;
        @(negedge clk); beat_take[0] = 1'b0;
        wr(6'd33, 32'h1);
        chk("R7 abort pending", 64'(abort_busy[0]), 1);
        chk("R7 busy held", 64'(busy[0]), 1);
        chk("R7 issue off", 64'(issue_en[0]), 0);
        @(negedge clk); beat_done[0] = 1'b1;
        @(negedge clk); beat_done[0] = 1'b0;
        cyc(1);
        chk("R7 abort clear", 64'(abort_busy[0]), 0);
        chk("R7 idle", 64'(busy[0]), 0);
        chk("R7 no status", 64'(irq_status), 0);

        // R3 pacing on channel 1 with request line 5
        wr(6'd8, mk(1, 0, 5, 1));
        wr(6'd15, 32'd2);
        chk("R3 no credit", 64'({busy[1], issue_en[1]}), 64'b10);
        @(negedge clk); dreq[4] = 1'b1;
        @(negedge clk); dreq[4] = 1'b0; tmr[1] = 1'b1;
        @(negedge clk); tmr[1] = 1'b0;
        chk("R3 other lines ignored", 64'(issue_en[1]), 0);
        @(negedge clk); dreq[5] = 1'b1;
        @(negedge clk); dreq[5] = 1'b0;
        chk("R3 credit from line 5", 64'(issue_en[1]), 1);
        wr(6'd24, mk(1, 0, 60, 3));
        chk("R3 timer unpaced off", 64'(issue_en[3]), 0);
        @(negedge clk); tmr[1] = 1'b1;
        @(negedge clk); tmr[1] = 1'b0;
        chk("R3 credit from timer 1", 64'(issue_en[3]), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule